// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. A host raises a conversion request by pulling chip-select and convert-start low together. The sequencer then runs a timed acquire window with the comparator auto-zero switch closed. It opens that switch and moves the sample capacitors to ground for one clock. It then walks the trial bits from the top bit down to bit 0, using one comparator decision per bit.

The analog side is reduced to three signals. `dac_code` carries the trial code to the capacitive DAC. `zero_sw` and `samp_gnd` control the switches. `cmp_in` returns the comparator's decision, which is 1 when the input is at or above the trial level. A busy flag covers the whole conversion. The finished code goes into an output register that the host reads over a parallel bus. The bus is driven only while chip-select and read are both low. A shutdown input parks the sequencer.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts only when `cs_n` and `start_n` are both 0 and `shdn` is 0 at a rising clock edge while idle. `busy` goes to 1 after that edge.
- R2: The trial code `dac_code` is cleared to zero when a conversion starts, and it stays zero through the acquire phase.
- R3: While `busy` is 1, start requests are ignored. Every conversion keeps `busy` high for exactly ACQ_CYCLES + 1 + 2*WIDTH clocks.
- R4: Bits are tried from bit WIDTH-1 down to bit 0, two clocks per bit. On the first clock the bit is set in `dac_code`. On the second clock `cmp_in` is sampled, and the bit is kept if `cmp_in` is 1 and cleared if it is 0. The clock after the first trial's set shows `dac_code` = 1 in bit WIDTH-1 and 0 in every other bit.
- R5: `zero_sw` is 1 and `samp_gnd` is 0 for the first ACQ_CYCLES clocks of a conversion. The default of 24 clocks equals 480 ns at 50 MHz.
- R6: After the acquire phase, `zero_sw` is 0 and `samp_gnd` is 1 for one clock before the first trial, and they stay that way through all the trials.
- R7: `dbus_en` is 1 exactly when both `cs_n` and `rd_n` are 0. While it is 1, `dbus` carries the result register. Otherwise `dbus` is high-impedance.
- R8: `busy` falls on the same clock edge that loads the finished code into the result register.
- R9: While `shdn` is 1, the sequencer returns to idle on the next clock, with `busy` = 0 and `dac_code` = 0. The result register keeps its previous value.
- R10: The result register changes only at the end of a conversion, so a read during a conversion returns the previous result.
- R11: With a comparator that returns 1 when `dac_code` is no greater than the input value, the result equals that input value for all codes, including 0 and all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| start_n | input | 1 | Convert request, active low |
| rd_n | input | 1 | Read strobe, active low |
| shdn | input | 1 | Shutdown, active high |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial level |
| busy | output | 1 | Conversion in progress |
| zero_sw | output | 1 | Comparator auto-zero switch closed |
| samp_gnd | output | 1 | Sample capacitors switched to ground |
| dac_code | output | WIDTH | Trial code to the DAC |
| dbus | output | WIDTH | Result bus, high-impedance when not read |
| dbus_en | output | 1 | Result bus drivers enabled |

## Verification
The assertions assume that `cmp_in` settles within the clock that follows each change of `dac_code`. They also assume that `shdn` is either held across an edge or dropped cleanly, with no glitches. The bench derives `cmp_in` combinationally from `dac_code` against a chosen input value, so a decision is always ready at the sampling edge. All strobes change on the falling clock edge. The bench deliberately drives a start request during the acquire phase and reads the bus in the middle of a conversion, so the ignore and hold properties are actually exercised.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH      = 16,
  parameter int ACQ_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             start_n,
  input  logic             rd_n,
  input  logic             shdn,
  input  logic             cmp_in,
  output logic             busy,
  output logic             zero_sw,
  output logic             samp_gnd,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] dbus,
  output logic             dbus_en
);
  localparam int CW = $clog2(ACQ_CYCLES + 1);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_HOLD, S_SET, S_EVAL} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [WIDTH-1:0] sar, res;
  logic            go;

  assign go       = !cs_n && !start_n && !shdn;
  assign busy     = (st != S_IDLE);
  assign zero_sw  = (st == S_ACQ);
  assign samp_gnd = (st == S_HOLD) || (st == S_SET) || (st == S_EVAL);
  assign dac_code = sar;
  assign dbus_en  = !cs_n && !rd_n;
  assign dbus     = dbus_en ? res : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sar <= '0;
      res <= '0;
    end else if (shdn) begin
      st  <= S_IDLE;
      sar <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st  <= S_ACQ;
          sar <= '0;
          cnt <= '0;
        end
        S_ACQ: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ACQ_CYCLES - 1)) st <= S_HOLD;
        end
        S_HOLD: begin
          idx <= IW'(WIDTH - 1);
          st  <= S_SET;
        end
        S_SET: begin
          sar[idx] <= 1'b1;
          st       <= S_EVAL;
        end
        S_EVAL: begin
          sar[idx] <= cmp_in;
          if (idx == '0) begin
            res <= {sar[WIDTH-1:1], cmp_in};
            st  <= S_IDLE;
          end else begin
            idx <= idx - 1'b1;
            st  <= S_SET;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && go) |=> busy);

  p_sar_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && go) |=> (dac_code == '0 && cnt == '0));

  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACQ && go) |=> (st != S_ACQ || cnt != '0));

  p_one_new_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SET && !shdn) |=> $countones(dac_code & ~$past(dac_code)) == 1);

  p_acq_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACQ) |-> (zero_sw && !samp_gnd));

  p_hold_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACQ && cnt == CW'(ACQ_CYCLES - 1) && !shdn) |=>
      (!zero_sw && samp_gnd && dac_code == '0));

  p_shdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (!busy && dac_code == '0));

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(res));
endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  localparam int W   = 16;
  localparam int ACQ = 24;
  localparam int LEN = ACQ + 1 + 2 * W;
  localparam int NV  = 8;
  localparam logic [W-1:0] VEC [NV] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF,
                                        16'h1234, 16'hAAAA, 16'h5555, 16'h0001};

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, start_n = 1, rd_n = 1, shdn = 0;
  logic [W-1:0] vin = '0;
  logic cmp_in, busy, zero_sw, samp_gnd, dbus_en;
  logic [W-1:0] dac_code, dbus;
  int tests = 0, fails = 0;

  int n_busy;
  bit acq_ok, hold_ok, msb_ok;
  logic [W-1:0] mid_read;

  always #10 clk = ~clk;
  assign cmp_in = (dac_code <= vin);

  sar_conv_ctrl #(.WIDTH(W), .ACQ_CYCLES(ACQ)) u_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_n(start_n), .rd_n(rd_n),
    .shdn(shdn), .cmp_in(cmp_in), .busy(busy), .zero_sw(zero_sw),
    .samp_gnd(samp_gnd), .dac_code(dac_code), .dbus(dbus), .dbus_en(dbus_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_bus(output logic [W-1:0] v);
    cs_n = 0; rd_n = 0; #1;
    v = dbus;
    cs_n = 1; rd_n = 1;
  endtask

  task automatic run_conv(input logic [W-1:0] v, input int restart_at, input int read_at);
    @(negedge clk);
    vin = v; cs_n = 0; start_n = 0;
    @(negedge clk);
    cs_n = 1; start_n = 1;
    n_busy = 0; acq_ok = 1; hold_ok = 1; msb_ok = 0;
    while (busy && n_busy < 1000) begin
      if (n_busy < ACQ && !(zero_sw && !samp_gnd && dac_code == '0)) acq_ok = 0;
      if (n_busy == ACQ && !(!zero_sw && samp_gnd)) hold_ok = 0;
      if (n_busy > ACQ && !(!zero_sw && samp_gnd)) hold_ok = 0;
      if (n_busy == ACQ + 2 && dac_code == {1'b1, {(W-1){1'b0}}}) msb_ok = 1;
      if (n_busy == restart_at) begin cs_n = 0; start_n = 0; end
      if (n_busy == restart_at + 1) begin cs_n = 1; start_n = 1; end
      if (n_busy == read_at) read_bus(mid_read);
      n_busy++;
      @(negedge clk);
    end
    cs_n = 1; start_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset zero_sw", zero_sw, 0);
    chk("reset dac_code", dac_code, 0);
    chk("R7 bus idle", dbus_en, 0);

    for (int i = 0; i < NV; i++) begin
      run_conv(VEC[i], -10, -10);
      chk("R3 R8 busy length", n_busy, LEN);
      chk("R2 R5 acquire", acq_ok, 1);
      chk("R6 hold switches", hold_ok, 1);
      chk("R4 msb first trial", msb_ok, 1);
      read_bus(r);
      chk("R11 result code", r, VEC[i]);
    end

    // R1: start without chip-select
    @(negedge clk); cs_n = 1; start_n = 0;
    @(negedge clk); chk("R1 no cs no start", busy, 0);
    start_n = 1; cs_n = 0;
    @(negedge clk); chk("R1 cs only no start", busy, 0);
    cs_n = 1;

    // R3: restart attempt during acquire, R10: read mid-conversion
    prev = VEC[NV-1];
    run_conv(16'h3C5A, 5, 30);
    chk("R3 restart ignored", n_busy, LEN);
    chk("R10 mid read previous", mid_read, prev);
    read_bus(r);
    chk("R11 after restart attempt", r, 16'h3C5A);

    // R7 enable combinations
    @(negedge clk); cs_n = 0; rd_n = 1; #1; chk("R7 cs only", dbus_en, 0);
    cs_n = 1; rd_n = 0; #1; chk("R7 rd only", dbus_en, 0);
    cs_n = 0; rd_n = 0; #1; chk("R7 both", dbus_en, 1);
    chk("R7 bus value", dbus, 16'h3C5A);
    cs_n = 1; rd_n = 1;

    // R9: shutdown mid-conversion
    @(negedge clk); vin = 16'hFFFF; cs_n = 0; start_n = 0;
    @(negedge clk); cs_n = 1; start_n = 1;
    repeat (40) @(negedge clk);
    chk("R9 busy before shdn", busy, 1);
    shdn = 1;
    @(negedge clk);
    chk("R9 busy off", busy, 0);
    chk("R9 dac zero", dac_code, 0);
    @(negedge clk); cs_n = 0; start_n = 0;
    @(negedge clk); chk("R9 start blocked", busy, 0);
    cs_n = 1; start_n = 1; shdn = 0;
    read_bus(r);
    chk("R9 result kept", r, 16'h3C5A);

    run_conv(16'h0F0F, -10, -10);
    read_bus(r);
    chk("R11 after shutdown", r, 16'h0F0F);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule